// File: doc/BRIEF.md
# Early-Terminating Multiply Sequencer

This unit performs the integer multiply family of a small 32-bit processor core: a 32-bit product, a 32-bit product plus an addend, a 64-bit product, and a 64-bit product plus a 64-bit addend. It works over several clock cycles. Each cycle it consumes one 8-bit digit of the multiplier, starting from the least significant digit. It stops as soon as the multiplier digits that remain carry no information. The number of algorithm steps, m, therefore depends on the multiplier value and lies between 1 and 4.

On every cycle of an instruction the unit also drives the core's bus control outputs: the address, an active-low memory request, a sequential flag, an active-low opcode-fetch flag, a write flag and an access size. Only the first cycle is a real fetch. The cycles after it are internal. The last cycle tells the memory system that a sequential fetch follows. The core pulses `go` for one clock. The unit captures the operands and the program counter on that edge and pulses `done` in the cycle that presents the result.

The controller is a five-state machine. In IDLE the unit waits for `go`. FETCH is cycle 1. ACCUM is the extra cycle 2 of an accumulating operation. CALC covers the internal cycles at pc+3L. FINISH is the last cycle. The transitions are:
- IDLE→FETCH on `go`.
- FETCH→ACCUM for accumulating operations.
- FETCH→FINISH when the instruction takes two cycles.
- FETCH→CALC otherwise.
- ACCUM or CALC→FINISH when the next cycle is the last.
- ACCUM or CALC→CALC otherwise.
- FINISH→IDLE always.

Top module: `mul_seq`

## Requirements
- R1: `kind` selects the operation. Bit 0 set adds an addend. Bit 1 set gives a 64-bit result. The encodings are 00 = 32-bit product, 01 = 32-bit product plus `add_lo`, 10 = 64-bit product, 11 = 64-bit product plus {`add_hi`,`add_lo`}. A 32-bit result appears on `prod_lo` with `prod_hi` = 0. A 64-bit result appears on {`prod_hi`,`prod_lo`}. `sgn` = 1 treats both operands as two's complement and `sgn` = 0 treats them as unsigned.
- R2: m is the smallest k in 1..4 for which the multiplier fits in 8k bits. For signed operands, bits 31 down to 8k-1 must be all equal. For unsigned operands, bits 31 down to 8k must be zero.
- R3: An instruction lasts N = m + 1 + kind[0] + kind[1] cycles after the `go` edge. `done` is high for exactly one clock, in cycle N, and the result outputs are valid in that cycle.
- R4: In cycle 1, `addr` = pc+2L (L = 4 bytes), `opc_n` = 0, `mreq_n` = 1 and `seq` = 0.
- R5: In cycle 2 of an accumulating operation, `addr` stays at pc+2L. Every other cycle from 2 to N uses pc+3L. Cycles 2 to N-1 drive `opc_n` = 1, `mreq_n` = 1 and `seq` = 0.
- R6: In cycle N, `mreq_n` = 0, `seq` = 1 and `opc_n` = 1.
- R7: Throughout an instruction, `wr` = 0 and `size` = 2'b10 (word).
- R8: The operands, addend and pc are taken on the `go` edge. A `go` pulse while an instruction is in progress has no effect, and neither does an operand change.
- R9: After reset and between instructions, `done` = 0, `mreq_n` = 1, `seq` = 0 and `opc_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, accepted only when idle |
| kind | input | 2 | Operation: bit 0 accumulate, bit 1 long |
| sgn | input | 1 | Signed operands when 1 |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier (sets m) |
| add_hi | input | 32 | Upper addend word (long accumulate) |
| add_lo | input | 32 | Lower addend word |
| pc | input | 32 | Program counter of the instruction |
| prod_hi | output | 32 | Upper result word (0 for 32-bit ops) |
| prod_lo | output | 32 | Lower result word |
| done | output | 1 | One-clock pulse in the last cycle |
| addr | output | 32 | Bus address |
| mreq_n | output | 1 | Active-low memory request for the next cycle |
| seq | output | 1 | Next access is sequential |
| opc_n | output | 1 | Active-low opcode-fetch flag |
| wr | output | 1 | Write flag, 0 throughout |
| size | output | 2 | Access size, word |

## Verification
The assertions check on every cycle that:
- `done` lasts one clock;
- the opcode-fetch flag is asserted for a single cycle;
- the request/sequential pair marks only the last cycle;
- the accumulated sum is complete and frozen once `done` rises;
- captured operands stay still while an instruction runs.

Only the bench's scenarios can show the rest, because each needs an arithmetic reference:
- that each multiplier value lands on the right m;
- that the total cycle count and the per-cycle address pattern match each of the four operations;
- that the result equals the arithmetic product plus addend for both signednesses.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;

    typedef enum logic [1:0] {
        K_MUL   = 2'b00,
        K_MAC   = 2'b01,
        K_MULL  = 2'b10,
        K_MACL  = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_ACCUM,
        S_CALC,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/mul_seq_span.sv
module mul_seq_span #(
    parameter int W     = 32,
    parameter int DIGIT = 8,
    parameter int NDIG  = W / DIGIT,
    parameter int MW    = $clog2(NDIG + 1)
) (
    input  logic          sgn,
    input  logic [W-1:0]  mplier,
    output logic [MW-1:0] steps
);

    logic [NDIG-1:1] fits;

    generate
        for (genvar k = 1; k < NDIG; k++) begin : g_fit
            logic [W-1:0] upper_s;
            logic [W-1:0] upper_u;
            assign upper_s = $signed(mplier) >>> (DIGIT * k - 1);
            assign upper_u = mplier >> (DIGIT * k);
            assign fits[k] = sgn ? ((&upper_s) || (~|upper_s)) : (~|upper_u);
        end
    endgenerate

    always_comb begin
        steps = MW'(NDIG);
        for (int k = NDIG - 1; k >= 1; k--) begin
            if (fits[k]) begin
                steps = MW'(k);
            end
        end
    end

endmodule

// File: rtl/mul_seq_dp.sv
module mul_seq_dp #(
    parameter int W     = 32,
    parameter int DIGIT = 8,
    parameter int NDIG  = W / DIGIT,
    parameter int MW    = $clog2(NDIG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          busy,
    input  logic          sgn,
    input  logic          acc_op,
    input  logic          long_op,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  add_hi,
    input  logic [W-1:0]  add_lo,
    input  logic [MW-1:0] steps_in,
    output logic          prod_ready,
    output logic [W-1:0]  prod_hi,
    output logic [W-1:0]  prod_lo
);

    localparam int DW = 2 * W;

    logic [DW-1:0] mcand_r;
    logic [W-1:0]  mplier_r;
    logic [DW-1:0] sum_r;
    logic [MW-1:0] idx_r;
    logic [MW-1:0] steps_r;
    logic          sgn_r;
    logic          long_r;

    logic [W-1:0]     mplier_sh;
    logic [DIGIT-1:0] chunk;
    logic             top_digit;
    logic [DW-1:0]    dig_ext;
    logic [DW-1:0]    part;
    logic [DW-1:0]    part_sh;

    assign prod_ready = (idx_r == steps_r);

    always_comb begin
        mplier_sh = mplier_r >> (idx_r * DIGIT);
        chunk     = mplier_sh[DIGIT-1:0];
        top_digit = sgn_r && ((idx_r + MW'(1)) == steps_r);
        if (top_digit) begin
            dig_ext = {{(DW-DIGIT){chunk[DIGIT-1]}}, chunk};
        end else begin
            dig_ext = {{(DW-DIGIT){1'b0}}, chunk};
        end
        part    = mcand_r * dig_ext;
        part_sh = part << (idx_r * DIGIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_r  <= '0;
            mplier_r <= '0;
            sum_r    <= '0;
            idx_r    <= '0;
            steps_r  <= '0;
            sgn_r    <= 1'b0;
            long_r   <= 1'b0;
        end else if (load) begin
            mcand_r  <= sgn ? {{W{opa[W-1]}}, opa} : {{W{1'b0}}, opa};
            mplier_r <= opb;
            sgn_r    <= sgn;
            long_r   <= long_op;
            idx_r    <= '0;
            steps_r  <= steps_in;
            if (!acc_op) begin
                sum_r <= '0;
            end else if (long_op) begin
                sum_r <= {add_hi, add_lo};
            end else begin
                sum_r <= {{W{1'b0}}, add_lo};
            end
        end else if (busy && !prod_ready) begin
            sum_r <= sum_r + part_sh;
            idx_r <= idx_r + MW'(1);
        end
    end

    assign prod_lo = sum_r[W-1:0];
    assign prod_hi = long_r ? sum_r[DW-1:W] : '0;

    // R8
    operands_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> ($stable(mcand_r) && $stable(mplier_r)));

    // R2
    sum_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_ready && !load) |=> $stable(sum_r));

endmodule

// File: rtl/mul_seq_ctl.sv
module mul_seq_ctl
    import mul_seq_pkg::*;
#(
    parameter int W    = 32,
    parameter int ILEN = 4,
    parameter int MW   = 3,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          acc_op,
    input  logic          long_op,
    input  logic [MW-1:0] steps_in,
    input  logic [W-1:0]  pc,
    output logic          busy,
    output logic          load,
    output logic          done,
    output logic [W-1:0]  addr,
    output logic          mreq_n,
    output logic          seq,
    output logic          opc_n,
    output logic          wr,
    output logic [1:0]    size
);

    localparam logic [1:0] SZ_CODE = (ILEN == 4) ? 2'b10 : ((ILEN == 2) ? 2'b01 : 2'b00);
    localparam logic [W-1:0] OFS2 = W'(2 * ILEN);
    localparam logic [W-1:0] OFS3 = W'(3 * ILEN);

    seq_state_e    state, state_nx;
    logic [CW-1:0] cnt_r;
    logic [CW-1:0] total_r;
    logic [W-1:0]  pc_r;
    logic          acc_r;
    logic          last_nx;

    assign load    = go && (state == S_IDLE);
    assign busy    = (state != S_IDLE);
    assign last_nx = ((cnt_r + CW'(1)) == total_r);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (load) state_nx = S_FETCH;
            S_FETCH: begin
                if (acc_r)                      state_nx = S_ACCUM;
                else if (total_r == CW'(2))     state_nx = S_FINISH;
                else                            state_nx = S_CALC;
            end
            S_ACCUM:  state_nx = last_nx ? S_FINISH : S_CALC;
            S_CALC:   state_nx = last_nx ? S_FINISH : S_CALC;
            S_FINISH: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt_r   <= '0;
            total_r <= '0;
            pc_r    <= '0;
            acc_r   <= 1'b0;
        end else begin
            state <= state_nx;
            if (load) begin
                cnt_r   <= CW'(1);
                total_r <= CW'(steps_in) + CW'(1) + CW'(acc_op) + CW'(long_op);
                pc_r    <= pc;
                acc_r   <= acc_op;
            end else if (busy) begin
                cnt_r <= cnt_r + CW'(1);
            end
        end
    end

    always_comb begin
        addr   = pc;
        mreq_n = 1'b1;
        seq    = 1'b0;
        opc_n  = 1'b1;
        done   = 1'b0;
        wr     = 1'b0;
        size   = SZ_CODE;
        unique case (state)
            S_IDLE: begin
                addr = pc;
            end
            S_FETCH: begin
                addr  = pc_r + OFS2;
                opc_n = 1'b0;
            end
            S_ACCUM: begin
                addr = pc_r + OFS2;
            end
            S_CALC: begin
                addr = pc_r + OFS3;
            end
            S_FINISH: begin
                addr   = pc_r + OFS3;
                mreq_n = 1'b0;
                seq    = 1'b1;
                done   = 1'b1;
            end
        endcase
    end

    // R4
    fetch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!opc_n) |=> opc_n);

    // R6
    finish_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n) |=> (state == S_IDLE));

endmodule

// File: rtl/mul_seq.sv
module mul_seq
    import mul_seq_pkg::*;
#(
    parameter int W     = 32,
    parameter int DIGIT = 8,
    parameter int ILEN  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [1:0]   kind,
    input  logic         sgn,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] add_hi,
    input  logic [W-1:0] add_lo,
    input  logic [W-1:0] pc,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         done,
    output logic [W-1:0] addr,
    output logic         mreq_n,
    output logic         seq,
    output logic         opc_n,
    output logic         wr,
    output logic [1:0]   size
);

    localparam int NDIG = W / DIGIT;
    localparam int MW   = $clog2(NDIG + 1);
    localparam int CW   = $clog2(NDIG + 4);

    logic          acc_op;
    logic          long_op;
    logic [MW-1:0] steps;
    logic          busy;
    logic          load;
    logic          prod_ready;

    assign acc_op  = kind[0];
    assign long_op = kind[1];

    mul_seq_span #(.W(W), .DIGIT(DIGIT), .NDIG(NDIG), .MW(MW)) u_span (
        .sgn    (sgn),
        .mplier (opb),
        .steps  (steps)
    );

    mul_seq_dp #(.W(W), .DIGIT(DIGIT), .NDIG(NDIG), .MW(MW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .busy       (busy),
        .sgn        (sgn),
        .acc_op     (acc_op),
        .long_op    (long_op),
        .opa        (opa),
        .opb        (opb),
        .add_hi     (add_hi),
        .add_lo     (add_lo),
        .steps_in   (steps),
        .prod_ready (prod_ready),
        .prod_hi    (prod_hi),
        .prod_lo    (prod_lo)
    );

    mul_seq_ctl #(.W(W), .ILEN(ILEN), .MW(MW), .CW(CW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .acc_op   (acc_op),
        .long_op  (long_op),
        .steps_in (steps),
        .pc       (pc),
        .busy     (busy),
        .load     (load),
        .done     (done),
        .addr     (addr),
        .mreq_n   (mreq_n),
        .seq      (seq),
        .opc_n    (opc_n),
        .wr       (wr),
        .size     (size)
    );

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    steps_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> prod_ready);

    // R6
    last_cycle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n) |-> (seq && done && opc_n));

endmodule

// File: tb/mul_seq_test.sv
module mul_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic        sgn = 1'b0;
    logic [31:0] opa = '0, opb = '0, add_hi = '0, add_lo = '0, pc = '0;
    logic [31:0] prod_hi, prod_lo, addr;
    logic        done, mreq_n, seq, opc_n, wr;
    logic [1:0]  size;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    mul_seq uut (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .sgn(sgn),
        .opa(opa), .opb(opb), .add_hi(add_hi), .add_lo(add_lo), .pc(pc),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .done(done), .addr(addr),
        .mreq_n(mreq_n), .seq(seq), .opc_n(opc_n), .wr(wr), .size(size)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_steps(input logic s, input logic [31:0] b);
        longint v;
        if (s) begin
            v = longint'($signed(b));
            if (v >= -128 && v <= 127) return 1;
            if (v >= -32768 && v <= 32767) return 2;
            if (v >= -8388608 && v <= 8388607) return 3;
            return 4;
        end
        if (b < 32'h100) return 1;
        if (b < 32'h1_0000) return 2;
        if (b < 32'h100_0000) return 3;
        return 4;
    endfunction

    // One instruction: bus pattern each cycle, cycle count and result.
    task automatic run_op(input logic [1:0] k, input logic s,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] ah, input logic [31:0] al,
                          input logic [31:0] p, input bit intrude);
        logic [63:0] ea, eb, prod, sum, got;
        int n, cyc;
        bit seen;
        logic [31:0] ex_addr;
        ea = s ? {{32{a[31]}}, a} : {32'b0, a};
        eb = s ? {{32{b[31]}}, b} : {32'b0, b};
        prod = ea * eb;
        if (k[1]) sum = prod + (k[0] ? {ah, al} : 64'd0);
        else      sum = {32'b0, prod[31:0] + (k[0] ? al : 32'd0)};
        n = exp_steps(s, b) + 1 + int'(k[0]) + int'(k[1]);

        @(negedge clk);
        kind = k; sgn = s; opa = a; opb = b; add_hi = ah; add_lo = al; pc = p;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cyc = 1;
        seen = 0;
        while (!seen && cyc <= 12) begin
            ex_addr = (cyc == 1 || (cyc == 2 && k[0])) ? p + 32'd8 : p + 32'd12;
            // R4 R5 R6: address and control pattern
            check(addr == ex_addr, "R4/R5 addr", {32'b0, addr}, {32'b0, ex_addr});
            check(opc_n == (cyc != 1), "R4 opc_n", {63'b0, opc_n}, {63'b0, cyc != 1});
            check(mreq_n == (cyc != n) && seq == (cyc == n), "R6 mreq_n/seq",
                  {62'b0, mreq_n, seq}, {62'b0, cyc != n, cyc == n});
            // R7
            check(wr == 1'b0 && size == 2'b10, "R7 wr/size",
                  {61'b0, wr, size}, {61'b0, 1'b0, 2'b10});
            if (done) begin
                seen = 1;
                // R3 cycle count
                check(cyc == n, "R3 length", 64'(cyc), 64'(n));
                got = {prod_hi, prod_lo};
                // R1 R2 R8 result
                check(got == sum, "R1 result", got, sum);
            end else begin
                if (intrude && cyc == 2) begin
                    go = 1'b1; opa = ~a; opb = b ^ 32'h5A5A_0000;
                    add_hi = ~ah; add_lo = ~al; pc = p + 32'h40;
                end else if (intrude && cyc == 3) begin
                    go = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        if (!seen) check(1'b0, "R3 no done", 64'(cyc), 64'(n));
        go = 1'b0;
        @(negedge clk);
        // R9 idle between instructions
        check(!done && mreq_n && !seq && opc_n, "R9 idle",
              {60'b0, done, mreq_n, seq, opc_n}, {60'b0, 4'b0101});
    endtask

    logic [31:0] bvals [19];
    logic [31:0] avals [3];

    initial begin
        bvals[0]  = 32'h0000_0000; bvals[1]  = 32'h0000_0001; bvals[2]  = 32'h0000_007F;
        bvals[3]  = 32'h0000_0080; bvals[4]  = 32'h0000_00FF; bvals[5]  = 32'h0000_0100;
        bvals[6]  = 32'hFFFF_FFFF; bvals[7]  = 32'hFFFF_FF80; bvals[8]  = 32'hFFFF_FF7F;
        bvals[9]  = 32'h0000_FFFF; bvals[10] = 32'h0001_0000; bvals[11] = 32'h0000_7FFF;
        bvals[12] = 32'h0000_8000; bvals[13] = 32'h00FF_FFFF; bvals[14] = 32'h0100_0000;
        bvals[15] = 32'h8000_0000; bvals[16] = 32'h7FFF_FFFF; bvals[17] = 32'hFF80_0000;
        bvals[18] = 32'hFF7F_FFFF;
        avals[0] = 32'h0000_0003; avals[1] = 32'h8765_4321; avals[2] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        // R9 reset state
        check(!done && mreq_n && !seq && opc_n, "R9 reset",
              {60'b0, done, mreq_n, seq, opc_n}, {60'b0, 4'b0101});
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 19; i++) begin
                    for (int j = 0; j < 3; j++) begin
                        run_op(2'(k), 1'(s), avals[j], bvals[i],
                               32'h1357_9BDF ^ 32'(i), 32'hFEDC_BA98 + 32'(j),
                               32'h0000_1000 + 32'(i * 64 + j * 16), 1'b0);
                    end
                end
            end
        end
        // R8: go and operand changes during an instruction are ignored
        run_op(2'b11, 1'b1, 32'h1234_5678, 32'h8000_0001, 32'h0000_0001, 32'h0000_0002,
               32'h0000_2000, 1'b1);
        run_op(2'b00, 1'b0, 32'h0000_0005, 32'h0001_0003, 32'h0, 32'h0,
               32'h0000_3000, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule